// File: doc/BRIEF.md
# PWM Generator with Latched External Clear

This block produces a single edge-aligned pulse-width-modulated reference from an up-counter. The counter steps from zero to a programmable wrap value and then restarts at zero. The reference is high while the count lies below a compare value. A complete period therefore lasts wrap+1 cycles, of which compare cycles are high. Both the wrap value and the compare value pass through shadow registers. A new setting therefore never takes effect partway through a period.

An asynchronous clear line, with a selectable active level, can cut a pulse short. The line passes through a two-flop synchronizer. When clear is enabled and the line is active, the reference drops low and stays low for the rest of the period. The output is re-armed only at a wrap where the line has gone inactive. With clear disabled, the line has no effect. A typical use is cycle-by-cycle current limiting, where a comparator trips the clear line and the next period restarts the pulse.

Top module: `pwmclr_top`

## Requirements
- R1: While rst_ni is low and after its release, count_o is 0 and pwm_o is 0 until the counter is enabled.
- R2: With cnt_en_i high, count_o increments by one each cycle. In the cycle after count_o reaches the active wrap value, or is above it, count_o is 0.
- R3: While cnt_en_i is high and no clear is in effect, pwm_o is 1 exactly when count_o is below the active compare value.
- R4: If the active compare value exceeds the active wrap value, pwm_o stays 1 for the whole period (100% duty) whenever no clear is in effect.
- R5: While clr_en_i is 0, ext_clr_i and clr_pol_i have no effect on pwm_o.
- R6: While clr_en_i is 1, a level of ext_clr_i that is active and that was applied two clock edges earlier forces pwm_o to 0.
- R7: A clear stays latched after the line goes inactive. It is released only at a wrap (count_o at or above the wrap value, counter enabled) in which the synchronized line is inactive. If the line is still active at the wrap, pwm_o stays 0 into the next period.
- R8: clr_pol_i = 0 makes a high ext_clr_i active. clr_pol_i = 1 makes a low ext_clr_i active.
- R9: reload_i and compare_i are copied into the active values at each wrap, and on every cycle while cnt_en_i is 0. A change in the middle of a period takes effect only in the next period.
- R10: While cnt_en_i is 0, count_o holds its value and pwm_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter enable |
| reload_i | input | CNT_W | Wrap value, loaded into its shadow register at a wrap or while the counter is stopped |
| compare_i | input | CNT_W | Compare value, loaded into its shadow register the same way |
| clr_en_i | input | 1 | Enable for the external clear |
| ext_clr_i | input | 1 | Asynchronous external clear line |
| clr_pol_i | input | 1 | Clear polarity: 0 means active high, 1 means active low |
| count_o | output | CNT_W | Current count |
| pwm_o | output | 1 | PWM reference output |

## Verification
Directed runs cover four patterns, and each one separates one behaviour from the others. A plain duty sweep checks the compare decode. A compare value above the wrap value must give a flat high output. A held clear line with the enable off must leave the output unchanged. Short and long clear pulses with the enable on show the difference between a one-cycle synchronizer delay and a two-cycle delay. They also show the difference between a latch released at the wrap and one released only once the line drops. The polarity select is tried with both levels on the line. Wrap and compare values change mid-period, and this checks that only the next period uses them. Constrained random traffic then mixes enable gaps, short periods, clear bursts and polarity flips. The result is compared cycle by cycle against a reference model kept in the bench.

// File: rtl/pwmclr_pkg.sv
package pwmclr_pkg;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    POL_ACT_HIGH = 1'b0,
    POL_ACT_LOW  = 1'b1
  } clr_pol_e;
endpackage

// File: rtl/pwmclr_sync.sv
module pwmclr_sync
  import pwmclr_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic pol_i,
  output logic act_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  clr_pol_e pol;
  assign pol   = clr_pol_e'(pol_i);
  assign act_o = (pol == POL_ACT_LOW) ? ~chain_q[STAGES-1] : chain_q[STAGES-1];
endmodule

// File: rtl/pwmclr_timebase.sv
module pwmclr_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] compare_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] compare_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, rel_q, cmp_q;
  logic             shadow_ld;

  assign ovf_o     = en_i && (cnt_q >= rel_q);
  assign shadow_ld = ovf_o || !en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= ovf_o ? '0 : cnt_q + 1'b1;
    end
  end

  // active values only move at a wrap or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= '0;
      cmp_q <= '0;
    end else if (shadow_ld) begin
      rel_q <= reload_i;
      cmp_q <= compare_i;
    end
  end

  assign count_o   = cnt_q;
  assign reload_o  = rel_q;
  assign compare_o = cmp_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q < rel_q) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q >= rel_q) |=> (cnt_q == '0));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  p_shadow_mid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q < rel_q) |=> ($stable(rel_q) && $stable(cmp_q)));
endmodule

// File: rtl/pwmclr_ref.sv
module pwmclr_ref #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] compare_i,
  input  logic             ovf_i,
  input  logic             clr_en_i,
  input  logic             clr_act_i,
  output logic             pwm_o
);
  logic clr_q, clr_d, clr_eff, raw;

  // latch set by an active line, dropped only at a wrap with the line idle
  assign clr_d   = clr_en_i && (clr_act_i || (clr_q && !ovf_i));
  assign clr_eff = clr_en_i && (clr_q || clr_act_i);
  assign raw     = count_i < compare_i;
  assign pwm_o   = en_i && raw && !clr_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= clr_d;
  end

  p_force_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && clr_act_i) |-> !pwm_o);
  p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q && clr_en_i && !ovf_i) |=> (clr_q || !clr_en_i));
  p_ignore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_i |-> (pwm_o == (en_i && raw)));
  p_stopped_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pwm_o);
endmodule

// File: rtl/pwmclr_top.sv
module pwmclr_top
  import pwmclr_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] compare_i,
  input  logic             clr_en_i,
  input  logic             ext_clr_i,
  input  logic             clr_pol_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt, rel_act, cmp_act;
  logic             ovf, clr_act;

  pwmclr_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_clr_i),
    .pol_i  (clr_pol_i),
    .act_o  (clr_act)
  );

  pwmclr_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cnt_en_i),
    .reload_i (reload_i),
    .compare_i(compare_i),
    .count_o  (cnt),
    .reload_o (rel_act),
    .compare_o(cmp_act),
    .ovf_o    (ovf)
  );

  pwmclr_ref #(.CNT_W(CNT_W)) u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cnt_en_i),
    .count_i  (cnt),
    .compare_i(cmp_act),
    .ovf_i    (ovf),
    .clr_en_i (clr_en_i),
    .clr_act_i(clr_act),
    .pwm_o    (pwm_o)
  );

  assign count_o = cnt;

  p_full_duty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && cmp_act > rel_act && cnt <= rel_act && !clr_en_i) |-> pwm_o);
  p_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && $past(cnt_en_i) && $past(ovf)) |-> (cnt == '0));
endmodule

// File: tb/pwmclr_top_tb_top.sv
module pwmclr_top_tb_top;
  localparam int unsigned CNT_W    = 16;
  localparam time         CLK_PER  = 10ns;
  localparam int unsigned WATCHDOG = 150000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cnt_en_i = 1'b0;
  logic [CNT_W-1:0] reload_i = '0;
  logic [CNT_W-1:0] compare_i = '0;
  logic             clr_en_i = 1'b0;
  logic             ext_clr_i = 1'b0;
  logic             clr_pol_i = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic             pwm_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  // reference model state
  logic [CNT_W-1:0] m_cnt = '0, m_rel = '0, m_cmp = '0;
  logic             m_s1 = 1'b0, m_s2 = 1'b0, m_clr = 1'b0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  pwmclr_top #(.CNT_W(CNT_W)) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (cnt_en_i),
    .reload_i (reload_i),
    .compare_i(compare_i),
    .clr_en_i (clr_en_i),
    .ext_clr_i(ext_clr_i),
    .clr_pol_i(clr_pol_i),
    .count_o  (count_o),
    .pwm_o    (pwm_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_pwm();
    logic act = m_s2 ^ clr_pol_i;
    return cnt_en_i && (m_cnt < m_cmp) && !(clr_en_i && (m_clr || act));
  endfunction

  task automatic model_step();
    logic act = m_s2 ^ clr_pol_i;
    logic ovf = cnt_en_i && (m_cnt >= m_rel);
    m_clr = clr_en_i && (act || (m_clr && !ovf));
    if (!cnt_en_i || ovf) begin
      m_rel = reload_i;
      m_cmp = compare_i;
    end
    if (cnt_en_i) m_cnt = ovf ? '0 : m_cnt + 1'b1;
    m_s2 = m_s1;
    m_s1 = ext_clr_i;
  endtask

  task automatic cyc(logic en, int rel, int cmp, logic ce, logic ext, logic pol,
                     string tag);
    @(negedge clk_i);
    cnt_en_i  = en;
    reload_i  = CNT_W'(rel);
    compare_i = CNT_W'(cmp);
    clr_en_i  = ce;
    ext_clr_i = ext;
    clr_pol_i = pol;
    #1;
    chk(en ? "R2" : "R10", 32'(count_o), 32'(m_cnt));
    chk(tag, 32'(pwm_o), 32'(exp_pwm()));
    model_step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R1", 32'(count_o), 0);
    chk("R1", 32'(pwm_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", 32'(count_o), 0);
    chk("R1", 32'(pwm_o), 0);
    model_step();
    // R3: duty sweep, no clear
    for (int c = 0; c <= 7; c++)
      for (int k = 0; k < 14; k++) cyc(1, 5, c, 0, 0, 0, "R3");
    // R4: compare above wrap
    for (int k = 0; k < 20; k++) cyc(1, 4, 9, 0, 0, 0, "R4");
    // R5: clear line active but disabled, both polarities
    for (int k = 0; k < 20; k++) cyc(1, 6, 4, 0, 1, 0, "R5");
    for (int k = 0; k < 20; k++) cyc(1, 6, 4, 0, 0, 1, "R5");
    // R6/R7: short pulse latched to wrap, long pulse holding across wrap
    for (int k = 0; k < 10; k++) cyc(1, 9, 8, 1, 0, 0, "R6");
    for (int k = 0; k < 1; k++)  cyc(1, 9, 8, 1, 1, 0, "R6");
    for (int k = 0; k < 20; k++) cyc(1, 9, 8, 1, 0, 0, "R7");
    for (int k = 0; k < 25; k++) cyc(1, 9, 8, 1, 1, 0, "R7");
    for (int k = 0; k < 25; k++) cyc(1, 9, 8, 1, 0, 0, "R7");
    // R4 with clear: re-armed at next wrap
    for (int k = 0; k < 3; k++)  cyc(1, 5, 9, 1, 1, 0, "R4");
    for (int k = 0; k < 15; k++) cyc(1, 5, 9, 1, 0, 0, "R4");
    // R8: active-low line
    for (int k = 0; k < 15; k++) cyc(1, 7, 6, 1, 1, 1, "R8");
    for (int k = 0; k < 4; k++)  cyc(1, 7, 6, 1, 0, 1, "R8");
    for (int k = 0; k < 20; k++) cyc(1, 7, 6, 1, 1, 1, "R8");
    // R9: mid-period change applies next period
    for (int k = 0; k < 13; k++) cyc(1, 9, 4, 0, 0, 0, "R9");
    for (int k = 0; k < 20; k++) cyc(1, 3, 2, 0, 0, 0, "R9");
    // R10: stopped counter
    for (int k = 0; k < 10; k++) cyc(0, 3, 2, 0, 0, 0, "R10");
    for (int k = 0; k < 10; k++) cyc(1, 8, 5, 0, 0, 0, "R9");
    // constrained random
    begin
      logic en = 1, ce = 0, ext = 0, pol = 0;
      int rel = 6, cmp = 3;
      for (int k = 0; k < 4000; k++) begin
        if ($urandom_range(99) < 4)  en  = ~en;
        if (!en && $urandom_range(9) < 3) en = 1;
        if ($urandom_range(99) < 3)  rel = $urandom_range(15);
        if ($urandom_range(99) < 5)  cmp = $urandom_range(18);
        if ($urandom_range(99) < 2)  ce  = ~ce;
        if ($urandom_range(99) < 10) ext = ~ext;
        if ($urandom_range(999) < 5) pol = ~pol;
        cyc(en, rel, cmp, ce, ext, pol, !en ? "R10" : (ce ? "R6" : "R3"));
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule